// File: doc/BRIEF.md
# Single-Byte Two-Wire EEPROM Transfer Engine

This block sits behind a processor's register bus and moves exactly one byte at a time over a two-wire serial link to an external EEPROM. Software uses two registers: a data register and a control/status register. To send a byte, software loads the data register and then writes the send command code into the control register. To fetch a byte, software writes the fetch command code, and the byte that arrives is placed in the data register. While the byte is on the wire a busy flag is set. The busy flag drops when the transfer is over, and a one-cycle interrupt pulse fires in that same cycle. After a send, a status bit shows whether the EEPROM acknowledged the byte.

Each transfer has nine serial clock pulses. Eight of them carry data, most significant bit first, and the ninth is the acknowledge slot. The serial clock comes from the system clock through a divider. `HALF_DIV` is the number of system clocks in each half-period. The default of 320 gives about 78 kHz from a 50 MHz system clock. Between transfers the serial clock rests high. The data line is open-drain: the block only pulls it low or lets it go, and it reads the line back through a separate input. Multi-byte EEPROM sequences, such as the address phase, paging and write-cycle polling, are built by software from single-byte transfers.

The bit sequencer is a three-state machine:
- `ST_IDLE`: the serial clock is high and the data line is released.
- `ST_CLK_LOW`: the clock is low and the outgoing bit is set up.
- `ST_CLK_HIGH`: the clock is high and the bit is held.

Its transitions are:
- `ST_IDLE -> ST_CLK_LOW` on an accepted command.
- `ST_CLK_LOW -> ST_CLK_HIGH` when the divider ends a half-period. The line is sampled at this rising edge.
- `ST_CLK_HIGH -> ST_CLK_LOW` at the end of a half-period for slots 0 to 7.
- `ST_CLK_HIGH -> ST_IDLE` at the end of slot 8. This is where the transfer completes and the interrupt fires.

Top module: `eebyte_engine`

## Requirements
- R1: After reset: `scl` is 1, `sda_drive_low` is 0, `irq` is 0, and both `ctrl_rdata` and `data_rdata` read 0.
- R2: A write with `reg_sel`=0 while idle loads `reg_wdata` into the data register, which reads back on `data_rdata`. A send leaves the data register unchanged.
- R3: A write with `reg_sel`=1 and `reg_wdata[1:0]`=01 while idle starts a send. The data register is shifted out MSB first over eight clock pulses, and `sda_drive_low` is 1 exactly for the 0 bits.
- R4: On the ninth pulse of a send the block releases the data line and samples it at the rising clock edge. Status bit `ctrl_rdata[6]` becomes 1 if the line was low and 0 if it was high. The bit keeps its value until the next send completes.
- R5: Code `reg_wdata[1:0]`=10 starts a fetch:
  - eight bits are sampled at rising clock edges, MSB first;
  - the line is left released (no-acknowledge) on the ninth pulse;
  - the byte lands in the data register;
  - `ctrl_rdata[6]` is unchanged.
- R6: `ctrl_rdata[7]` (busy) is 1 from the cycle after the command write for exactly 18*`HALF_DIV` cycles.
- R7: `irq` is a one-cycle pulse in the first cycle in which busy is 0 after a transfer.
- R8: `scl` is high whenever the block is idle. During a transfer, each low half and each high half of `scl` lasts `HALF_DIV` system clocks.
- R9: Register writes (data or control) made while busy is 1 have no effect.
- R10: Control writes with `reg_wdata[1:0]` equal to 00 or 11 start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 data, 1 control |
| reg_wdata | input | 8 | Write data; in control writes bits [1:0] are the command code |
| ctrl_rdata | output | 8 | Status: bit 7 busy, bit 6 acknowledge seen, other bits 0 |
| data_rdata | output | 8 | Data register contents |
| irq | output | 1 | Completion pulse, one system clock wide |
| scl | output | 1 | Serial clock, high when idle |
| sda_drive_low | output | 1 | Open-drain pull-down enable for the data line |
| sda_in | input | 1 | Sampled level of the data line |

## Verification
A register write can land in the last cycle of a transfer, when the completion edge also updates the data register and raises the interrupt. The bench places a data write in the final busy cycle and expects it to be lost. It then places another write in the interrupt cycle and expects that one to take effect. Separately, a write is made in the middle of a fetch, and the bench expects the fetched byte, not the written one, to be in the data register when the interrupt is observed.

// File: rtl/eebyte_pkg.sv
package eebyte_pkg;
    localparam int unsigned BYTE_W          = 8;
    localparam int unsigned SLOTS           = BYTE_W + 1;
    localparam int unsigned SLOT_W          = $clog2(SLOTS);
    localparam int unsigned STATUS_BUSY_BIT = 7;
    localparam int unsigned STATUS_ACK_BIT  = 6;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_SEND  = 2'b01,
        CMD_FETCH = 2'b10,
        CMD_RSVD  = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_CLK_LOW  = 2'b01,
        ST_CLK_HIGH = 2'b10
    } seq_state_e;
endpackage

// File: rtl/eebyte_divider.sv
module eebyte_divider #(
    parameter int unsigned HALF_DIV = 320
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic phase_end
);
    localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    assign phase_end = run && (cnt_q == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || phase_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/eebyte_seq.sv
module eebyte_seq
    import eebyte_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_rx,
    input  logic phase_end,
    input  logic tx_msb,
    output logic busy,
    output logic scl,
    output logic sda_drive_low,
    output logic rise_sample,
    output logic fall_advance,
    output logic xfer_done,
    output logic ack_slot,
    output logic rx_mode
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    seq_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic              rx_q;

    // state register and slot bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            rx_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                slot_q <= '0;
                rx_q   <= start_rx;
            end else if (state_q == ST_CLK_HIGH && phase_end && slot_q != LAST_SLOT) begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_CLK_LOW;
            ST_CLK_LOW:  if (phase_end) state_d = ST_CLK_HIGH;
            ST_CLK_HIGH: if (phase_end) state_d = (slot_q == LAST_SLOT) ? ST_IDLE : ST_CLK_LOW;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy          = (state_q != ST_IDLE);
        scl           = (state_q != ST_CLK_LOW);
        ack_slot      = (slot_q == LAST_SLOT);
        rx_mode       = rx_q;
        rise_sample   = (state_q == ST_CLK_LOW) && phase_end;
        fall_advance  = (state_q == ST_CLK_HIGH) && phase_end && !ack_slot;
        xfer_done     = (state_q == ST_CLK_HIGH) && phase_end && ack_slot;
        sda_drive_low = busy && !rx_q && !ack_slot && !tx_msb;
    end
endmodule

// File: rtl/eebyte_shreg.sv
module eebyte_shreg
    import eebyte_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              rise_sample,
    input  logic              fall_advance,
    input  logic              ack_slot,
    input  logic              rx_mode,
    input  logic              sda_in,
    output logic              tx_msb,
    output logic [BYTE_W-1:0] byte_out,
    output logic              ack_flag
);
    logic [BYTE_W-1:0] sh_q;
    logic              ack_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            ack_q <= 1'b0;
        end else begin
            if (load) begin
                sh_q <= load_val;
            end else if (rise_sample && rx_mode && !ack_slot) begin
                sh_q <= {sh_q[BYTE_W-2:0], sda_in};
            end else if (fall_advance && !rx_mode) begin
                sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
            end
            if (rise_sample && ack_slot && !rx_mode) begin
                ack_q <= !sda_in;
            end
        end
    end

    assign tx_msb   = sh_q[BYTE_W-1];
    assign byte_out = sh_q;
    assign ack_flag = ack_q;
endmodule

// File: rtl/eebyte_engine.sv
module eebyte_engine
    import eebyte_pkg::*;
#(
    parameter int unsigned HALF_DIV = 320
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] ctrl_rdata,
    output logic [7:0] data_rdata,
    output logic       irq,
    output logic       scl,
    output logic       sda_drive_low,
    input  logic       sda_in
);
    logic              busy, phase_end, rise_sample, fall_advance;
    logic              xfer_done, ack_slot, rx_mode, tx_msb, ack_flag;
    logic              start, start_rx, ctrl_ok;
    logic [BYTE_W-1:0] shift_byte, data_q;
    logic              irq_q;
    cmd_e              cmd;

    assign cmd      = cmd_e'(reg_wdata[1:0]);
    assign ctrl_ok  = reg_wr && reg_sel && !busy;
    assign start    = ctrl_ok && (cmd == CMD_SEND || cmd == CMD_FETCH);
    assign start_rx = (cmd == CMD_FETCH);

    eebyte_divider #(.HALF_DIV(HALF_DIV)) div_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .phase_end (phase_end)
    );

    eebyte_seq seq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .start_rx      (start_rx),
        .phase_end     (phase_end),
        .tx_msb        (tx_msb),
        .busy          (busy),
        .scl           (scl),
        .sda_drive_low (sda_drive_low),
        .rise_sample   (rise_sample),
        .fall_advance  (fall_advance),
        .xfer_done     (xfer_done),
        .ack_slot      (ack_slot),
        .rx_mode       (rx_mode)
    );

    eebyte_shreg shreg_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (start),
        .load_val     (data_q),
        .rise_sample  (rise_sample),
        .fall_advance (fall_advance),
        .ack_slot     (ack_slot),
        .rx_mode      (rx_mode),
        .sda_in       (sda_in),
        .tx_msb       (tx_msb),
        .byte_out     (shift_byte),
        .ack_flag     (ack_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= xfer_done;
            if (xfer_done && rx_mode) begin
                data_q <= shift_byte;
            end else if (reg_wr && !reg_sel && !busy) begin
                data_q <= reg_wdata;
            end
        end
    end

    always_comb begin
        ctrl_rdata                  = '0;
        ctrl_rdata[STATUS_BUSY_BIT] = busy;
        ctrl_rdata[STATUS_ACK_BIT]  = ack_flag;
    end

    assign data_rdata = data_q;
    assign irq        = irq_q;
endmodule

// File: rtl/eebyte_engine_chk.sv
module eebyte_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       ack_flag,
    input logic       irq,
    input logic       scl,
    input logic       sda_drive_low,
    input logic [7:0] data_q
);
    // R8: idle bus rests with clock high and data released
    p_idle_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl && !sda_drive_low));

    // R7: interrupt only in the first idle cycle after a transfer
    p_irq_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!busy && $past(busy)));

    // R7: every end of busy is flagged
    p_busy_fall_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq);

    // R7: pulse is one cycle wide
    p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R4: acknowledge status changes only during a transfer
    p_ack_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(ack_flag));

    // R9: data register untouched while busy
    p_data_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(data_q));
endmodule

bind eebyte_engine eebyte_engine_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (ctrl_rdata[7]),
    .ack_flag      (ctrl_rdata[6]),
    .irq           (irq),
    .scl           (scl),
    .sda_drive_low (sda_drive_low),
    .data_q        (data_rdata)
);

// File: tb/eebyte_engine_tb_top.sv
module eebyte_engine_tb_top;
    localparam int unsigned H = 4;
    localparam int XFER_LEN = 18 * H;

    typedef struct {
        bit       rx;
        bit [7:0] val;
        bit       ack;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] ctrl_rdata, data_rdata;
    logic       irq, scl, sda_drive_low;
    logic       sda_line;

    logic       slave_pull = 1'b0;
    bit         slave_rx_mode = 1'b0;
    bit         slave_ack_en = 1'b0;
    bit [7:0]   slave_byte = 8'h00;
    bit [7:0]   slave_cap = 8'h00;
    bit         ninth_level = 1'b0;
    int         nrise = 0;

    int   checks = 0;
    int   errors = 0;
    bit   last_ack = 1'b0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    assign sda_line = ~(sda_drive_low | slave_pull);

    eebyte_engine #(.HALF_DIV(H)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_sel       (reg_sel),
        .reg_wdata     (reg_wdata),
        .ctrl_rdata    (ctrl_rdata),
        .data_rdata    (data_rdata),
        .irq           (irq),
        .scl           (scl),
        .sda_drive_low (sda_drive_low),
        .sda_in        (sda_line)
    );

    // EEPROM model: captures sent bits, returns fetched bits, drives acknowledge
    always @(posedge scl) begin
        if (rst_n) begin
            if (nrise < 8 && !slave_rx_mode) slave_cap = {slave_cap[6:0], sda_line};
            if (nrise == 8) begin
                ninth_level = sda_line;
                slave_pull  = 1'b0;
                nrise       = 0;
            end else begin
                nrise = nrise + 1;
            end
        end
    end

    always @(negedge scl) begin
        if (rst_n) begin
            if (slave_rx_mode) slave_pull = (nrise < 8) ? ~slave_byte[7 - nrise] : 1'b0;
            else               slave_pull = (nrise == 8) ? slave_ack_en : 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input bit sel, input logic [7:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_done(output int len);
        len = 0;
        while (ctrl_rdata[7]) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic run_tx(input bit [7:0] b, input bit ack);
        int len;
        slave_rx_mode = 1'b0; slave_ack_en = ack;
        wr_reg(1'b0, b);
        exp_q.push_back('{rx: 1'b0, val: b, ack: ack});
        last_ack = ack;
        wr_reg(1'b1, 8'h01);
        wait_done(len);
        check(len == XFER_LEN, "R6 busy length", len, XFER_LEN);
    endtask

    task automatic run_rx(input bit [7:0] b);
        int len;
        slave_rx_mode = 1'b1; slave_byte = b;
        exp_q.push_back('{rx: 1'b1, val: b, ack: last_ack});
        wr_reg(1'b1, 8'h02);
        wait_done(len);
        check(len == XFER_LEN, "R6 busy length", len, XFER_LEN);
    endtask

    // scoreboard monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && irq) begin
                check(ctrl_rdata[7] == 1'b0, "R7 busy low with irq", ctrl_rdata[7], 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected irq", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    if (e.rx) begin
                        check(data_rdata == e.val, "R5 fetched byte", data_rdata, e.val);
                        check(ninth_level == 1'b1, "R5 no-ack released", ninth_level, 1);
                        check(ctrl_rdata[6] == e.ack, "R5 ack bit unchanged", ctrl_rdata[6], e.ack);
                    end else begin
                        check(slave_cap == e.val, "R3 sent byte", slave_cap, e.val);
                        check(ctrl_rdata[6] == e.ack, "R4 ack status", ctrl_rdata[6], e.ack);
                        check(data_rdata == e.val, "R2 data kept after send", data_rdata, e.val);
                    end
                end
                @(negedge clk);
                check(irq == 1'b0, "R7 irq one cycle", irq, 0);
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int len;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(scl == 1'b1, "R1 scl reset", scl, 1);
        check(sda_drive_low == 1'b0, "R1 sda reset", sda_drive_low, 0);
        check(irq == 1'b0, "R1 irq reset", irq, 0);
        check(ctrl_rdata == 8'h00, "R1 ctrl reset", ctrl_rdata, 0);
        check(data_rdata == 8'h00, "R1 data reset", data_rdata, 0);

        // R2 data write when idle
        wr_reg(1'b0, 8'hC3);
        check(data_rdata == 8'hC3, "R2 data readback", data_rdata, 8'hC3);

        // R8 phase lengths on first send
        slave_rx_mode = 1'b0; slave_ack_en = 1'b1;
        exp_q.push_back('{rx: 1'b0, val: 8'hC3, ack: 1'b1});
        last_ack = 1'b1;
        wr_reg(1'b1, 8'h01);
        for (int i = 0; i < H; i++) begin
            check(scl == 1'b0, "R8 low half length", scl, 0);
            @(negedge clk);
        end
        for (int i = 0; i < H; i++) begin
            check(scl == 1'b1, "R8 high half length", scl, 1);
            @(negedge clk);
        end
        check(scl == 1'b0, "R8 second low half", scl, 0);
        wait_done(len);
        check(scl == 1'b1, "R8 scl idle high", scl, 1);

        run_tx(8'hA5, 1'b1);
        run_tx(8'h3C, 1'b0);
        run_tx(8'h00, 1'b1);
        run_rx(8'h96);
        run_rx(8'h00);
        run_rx(8'hFF);

        // R10 reserved and no-op codes
        wr_reg(1'b1, 8'h00);
        repeat (3) @(negedge clk);
        check(ctrl_rdata[7] == 1'b0, "R10 code 00 ignored", ctrl_rdata[7], 0);
        check(scl == 1'b1, "R10 code 00 no clock", scl, 1);
        wr_reg(1'b1, 8'h03);
        repeat (3) @(negedge clk);
        check(ctrl_rdata[7] == 1'b0, "R10 code 11 ignored", ctrl_rdata[7], 0);

        // R9 writes during a fetch are lost
        slave_rx_mode = 1'b1; slave_byte = 8'h5E;
        exp_q.push_back('{rx: 1'b1, val: 8'h5E, ack: last_ack});
        wr_reg(1'b1, 8'h02);
        repeat (10) @(negedge clk);
        wr_reg(1'b0, 8'h11);
        wr_reg(1'b1, 8'h01);
        wait_done(len);
        check(data_rdata == 8'h5E, "R9 data write ignored", data_rdata, 8'h5E);
        repeat (4) @(negedge clk);
        check(ctrl_rdata[7] == 1'b0, "R9 command ignored", ctrl_rdata[7], 0);

        // boundary: write in last busy cycle lost, write in irq cycle taken
        wr_reg(1'b0, 8'h47);
        slave_rx_mode = 1'b0; slave_ack_en = 1'b0;
        exp_q.push_back('{rx: 1'b0, val: 8'h47, ack: 1'b0});
        last_ack = 1'b0;
        wr_reg(1'b1, 8'h01);
        repeat (XFER_LEN - 1) @(negedge clk);
        check(ctrl_rdata[7] == 1'b1, "R6 last busy cycle", ctrl_rdata[7], 1);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h5A;
        @(negedge clk);
        reg_wr = 1'b0;
        check(irq == 1'b1, "R7 irq at end", irq, 1);
        check(data_rdata == 8'h47, "R9 write in last busy cycle", data_rdata, 8'h47);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h6B;
        @(negedge clk);
        reg_wr = 1'b0;
        check(data_rdata == 8'h6B, "R2 write in irq cycle", data_rdata, 8'h6B);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R7 all completions seen", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule